// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block keeps the per-channel control and status bits of a DMA engine with up to 64 channels: request enable, error-interrupt enable, pending interrupt, pending error and transfer-done. Each 64-bit vector is read and written as two 32-bit words. The low word holds channels 31..0 and the high word holds channels 63..32. A configuration with 32 channels or fewer uses only the low words.

Software can also change the bit of one channel without a read-modify-write. It writes that channel's number to a dedicated byte-wide command address: set or clear the request enable, set or clear the error-interrupt enable, clear the interrupt, clear the error, clear done, or start the channel.

The channel engines report events on input pulses: done and interrupt as vectors, and errors as a channel number with a cause code. A global error status word keeps the first error that is reported, with its channel number and its cause flags. The block drives the channel enable vector, a one-cycle start pulse for each channel, and a single interrupt line.

Top module: `dma_chan_csr`

Register addresses (5-bit word index on `reg_addr`/`reg_raddr`):

| Index | Register | Access |
|---|---|---|
| 0 / 1 | enable, low / high word | read, write |
| 2 / 3 | error-interrupt enable, low / high word | read, write |
| 4 / 5 | interrupt pending, low / high word | read, write-1-to-clear |
| 6 / 7 | error pending, low / high word | read, write-1-to-clear |
| 8 / 9 | done, low / high word | read, write-1-to-clear |
| 10 / 11 | hardware request status, low / high word | read only |
| 12 | error status | read only |
| 16 / 17 | set / clear enable | command |
| 18 / 19 | set / clear error-interrupt enable | command |
| 20 / 21 | clear interrupt / clear error | command |
| 22 / 23 | start / clear done | command |

## Requirements
- R1: After reset, every vector, the error status word, `ch_enable`, `ch_start` and `irq` are all zero.
- R2: A write to the enable or error-interrupt-enable word at index 0/1 or 2/3 replaces that word with `reg_wdata`. The new value shows on `ch_enable` and on read-back after the clock edge that takes the write.
- R3: A write to a command address (16..23) acts only on the channel that `reg_wdata[5:0]` names. The command is ignored if `reg_wdata[7:6]` is not zero or if the channel number is NUM_CH or larger.
- R4: The interrupt, error and done words (indices 4..9) are write-1-to-clear: each 1 in `reg_wdata` clears that bit and each 0 leaves it unchanged. Writing all ones clears the whole word.
- R5: `ev_int[i]`, `ev_done[i]` and an `ev_err` pulse naming channel i set the matching pending bit. A hardware set wins over a software clear of the same bit in the same cycle.
- R6: A write to the start command gives `ch_start` a one-hot, one-cycle pulse for the named channel in the cycle after the write edge. Without such a write, `ch_start` is zero.
- R7: An accepted error captures the error status word as follows: bit 31 = valid, bits 15:14 = `ev_err_cause[9:8]` (group priority, channel priority), bits 13:8 = channel number, bits 7:0 = `ev_err_cause[7:0]` (bit 7 source address down to bit 0 destination bus). All other bits read zero.
- R8: While the valid bit is set, later errors set their pending bits but leave the error status word unchanged.
- R9: When the error-pending vector becomes all zero, the error status word returns to zero in the same edge, so the next error is captured again.
- R10: `irq` is high exactly when an interrupt bit is pending, or an error bit is pending whose error-interrupt enable is set.
- R11: Indices 10 and 11 return `hw_req[31:0]` and `hw_req[63:32]` in the same cycle.
- R12: Reading an unassigned index (13..15, 24..31) returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 5 | Write word index |
| reg_wdata | input | 32 | Write data; command addresses use bits 7:0 |
| reg_raddr | input | 5 | Read word index |
| reg_rdata | output | 32 | Read data, combinational from `reg_raddr` |
| ev_done | input | NUM_CH | Per-channel done pulses |
| ev_int | input | NUM_CH | Per-channel interrupt pulses |
| ev_err | input | 1 | Error report pulse |
| ev_err_ch | input | 6 | Channel number of the error report |
| ev_err_cause | input | 10 | Cause flags of the error report |
| hw_req | input | NUM_CH | Live hardware request lines |
| ch_enable | output | NUM_CH | Request enable per channel |
| ch_start | output | NUM_CH | One-cycle start pulse per channel |
| irq | output | 1 | Combined interrupt |

## Verification
Every write, command and event is taken at one rising edge. The state it changes can be seen on `reg_rdata`, `ch_enable`, `irq` and the error status word during the cycle that follows, so there is no extra latency. The start pulse is the single exception: it is registered and is high only during the one cycle after the command edge. The bench drives inputs on the falling edge and reads results on the next falling edge. It checks the start pulse once in that first cycle and again one cycle later to confirm it has gone. The bench also drives a hardware set and a software clear of the same bit in the same cycle to check the priority stated in R5.

// File: rtl/dma_csr_pkg.sv
`timescale 1ns/1ps
package dma_csr_pkg;
    localparam int CH_MAX   = 64;
    localparam int CH_IDX_W = 6;
    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 5;
    localparam int CAUSE_W  = 10;

    typedef enum logic [ADDR_W-1:0] {
        A_ENA_LO   = 5'd0,
        A_ENA_HI   = 5'd1,
        A_EIE_LO   = 5'd2,
        A_EIE_HI   = 5'd3,
        A_IRQ_LO   = 5'd4,
        A_IRQ_HI   = 5'd5,
        A_ERR_LO   = 5'd6,
        A_ERR_HI   = 5'd7,
        A_DONE_LO  = 5'd8,
        A_DONE_HI  = 5'd9,
        A_HWRQ_LO  = 5'd10,
        A_HWRQ_HI  = 5'd11,
        A_ESTAT    = 5'd12,
        A_SET_ENA  = 5'd16,
        A_CLR_ENA  = 5'd17,
        A_SET_EIE  = 5'd18,
        A_CLR_EIE  = 5'd19,
        A_CLR_IRQ  = 5'd20,
        A_CLR_ERR  = 5'd21,
        A_START    = 5'd22,
        A_CLR_DONE = 5'd23
    } csr_addr_e;

    // Update controls for one 64-bit state vector
    typedef struct packed {
        logic                wr_lo;
        logic                wr_hi;
        logic                set_vld;
        logic [CH_IDX_W-1:0] set_ch;
        logic                clr_vld;
        logic [CH_IDX_W-1:0] clr_ch;
    } vec_ctl_t;
endpackage

// File: rtl/dma_csr_decode.sv
`timescale 1ns/1ps
module dma_csr_decode
    import dma_csr_pkg::*;
#(
    parameter int NUM_CH = 64
) (
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        wbyte,
    output vec_ctl_t          ena_ctl,
    output vec_ctl_t          eie_ctl,
    output vec_ctl_t          irq_ctl,
    output vec_ctl_t          err_ctl,
    output vec_ctl_t          done_ctl,
    output logic              start_vld,
    output logic [CH_IDX_W-1:0] start_ch
);
    localparam logic [CH_IDX_W:0] NUM_CH_L = (CH_IDX_W+1)'(NUM_CH);

    logic                byte_ok;
    logic [CH_IDX_W-1:0] ch;

    assign ch      = wbyte[CH_IDX_W-1:0];
    assign byte_ok = (wbyte[7:6] == 2'b00) && ({1'b0, ch} < NUM_CH_L);

    always_comb begin
        ena_ctl  = '0;
        eie_ctl  = '0;
        irq_ctl  = '0;
        err_ctl  = '0;
        done_ctl = '0;
        ena_ctl.set_ch  = ch;  ena_ctl.clr_ch  = ch;
        eie_ctl.set_ch  = ch;  eie_ctl.clr_ch  = ch;
        irq_ctl.clr_ch  = ch;
        err_ctl.clr_ch  = ch;
        done_ctl.clr_ch = ch;
        start_vld = 1'b0;
        start_ch  = ch;
        if (reg_wr) begin
            case (reg_addr)
                A_ENA_LO:   ena_ctl.wr_lo    = 1'b1;
                A_ENA_HI:   ena_ctl.wr_hi    = 1'b1;
                A_EIE_LO:   eie_ctl.wr_lo    = 1'b1;
                A_EIE_HI:   eie_ctl.wr_hi    = 1'b1;
                A_IRQ_LO:   irq_ctl.wr_lo    = 1'b1;
                A_IRQ_HI:   irq_ctl.wr_hi    = 1'b1;
                A_ERR_LO:   err_ctl.wr_lo    = 1'b1;
                A_ERR_HI:   err_ctl.wr_hi    = 1'b1;
                A_DONE_LO:  done_ctl.wr_lo   = 1'b1;
                A_DONE_HI:  done_ctl.wr_hi   = 1'b1;
                A_SET_ENA:  ena_ctl.set_vld  = byte_ok;
                A_CLR_ENA:  ena_ctl.clr_vld  = byte_ok;
                A_SET_EIE:  eie_ctl.set_vld  = byte_ok;
                A_CLR_EIE:  eie_ctl.clr_vld  = byte_ok;
                A_CLR_IRQ:  irq_ctl.clr_vld  = byte_ok;
                A_CLR_ERR:  err_ctl.clr_vld  = byte_ok;
                A_START:    start_vld        = byte_ok;
                A_CLR_DONE: done_ctl.clr_vld = byte_ok;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dma_csr_vec.sv
`timescale 1ns/1ps
module dma_csr_vec
    import dma_csr_pkg::*;
#(
    parameter int NUM_CH = 64,
    parameter bit W1C    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  vec_ctl_t          ctl,
    input  logic [WORD_W-1:0] wdata,
    input  logic [NUM_CH-1:0] hw_set,
    output logic [NUM_CH-1:0] bits_d,
    output logic [NUM_CH-1:0] bits_q
);
    typedef struct packed {
        logic [NUM_CH-1:0] bits;
    } vec_st_t;

    vec_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CH; i++) begin
            // word write: replace, or clear where a 1 is written
            if ((i < WORD_W && ctl.wr_lo) || (i >= WORD_W && ctl.wr_hi)) begin
                if (W1C) begin
                    if (wdata[i % WORD_W]) st_d.bits[i] = 1'b0;
                end else begin
                    st_d.bits[i] = wdata[i % WORD_W];
                end
            end
            if (ctl.clr_vld && (int'(ctl.clr_ch) == i)) st_d.bits[i] = 1'b0;
            if (ctl.set_vld && (int'(ctl.set_ch) == i)) st_d.bits[i] = 1'b1;
            // hardware events take priority over any software clear
            if (hw_set[i]) st_d.bits[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bits_d = st_d.bits;
    assign bits_q = st_q.bits;
endmodule

// File: rtl/dma_csr_errstat.sv
`timescale 1ns/1ps
module dma_csr_errstat
    import dma_csr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_vld,
    input  logic [CH_IDX_W-1:0] cap_ch,
    input  logic [CAUSE_W-1:0]  cap_cause,
    input  logic                err_any_d,
    output logic [WORD_W-1:0]   estat_q
);
    typedef struct packed {
        logic                valid;
        logic [1:0]          prio;
        logic [CH_IDX_W-1:0] ch;
        logic [7:0]          flags;
    } es_st_t;

    es_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!err_any_d) begin
            st_d = '0;
        end else if (!st_q.valid && cap_vld) begin
            st_d.valid = 1'b1;
            st_d.prio  = cap_cause[9:8];
            st_d.ch    = cap_ch;
            st_d.flags = cap_cause[7:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign estat_q = {st_q.valid, 15'b0, st_q.prio, st_q.ch, st_q.flags};
endmodule

// File: rtl/dma_chan_csr.sv
`timescale 1ns/1ps
module dma_chan_csr
    import dma_csr_pkg::*;
#(
    parameter int NUM_CH = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    input  logic [ADDR_W-1:0]   reg_raddr,
    output logic [WORD_W-1:0]   reg_rdata,
    input  logic [NUM_CH-1:0]   ev_done,
    input  logic [NUM_CH-1:0]   ev_int,
    input  logic                ev_err,
    input  logic [CH_IDX_W-1:0] ev_err_ch,
    input  logic [CAUSE_W-1:0]  ev_err_cause,
    input  logic [NUM_CH-1:0]   hw_req,
    output logic [NUM_CH-1:0]   ch_enable,
    output logic [NUM_CH-1:0]   ch_start,
    output logic                irq
);
    localparam logic [CH_IDX_W:0] NUM_CH_L = (CH_IDX_W+1)'(NUM_CH);

    vec_ctl_t ena_ctl, eie_ctl, irq_ctl, err_ctl, done_ctl;
    logic                start_vld;
    logic [CH_IDX_W-1:0] start_ch;

    dma_csr_decode #(.NUM_CH(NUM_CH)) decode_i (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .wbyte     (reg_wdata[7:0]),
        .ena_ctl   (ena_ctl),
        .eie_ctl   (eie_ctl),
        .irq_ctl   (irq_ctl),
        .err_ctl   (err_ctl),
        .done_ctl  (done_ctl),
        .start_vld (start_vld),
        .start_ch  (start_ch)
    );

    // error report accepted only for an existing channel
    logic              err_acc;
    logic [NUM_CH-1:0] err_set;
    assign err_acc = ev_err && ({1'b0, ev_err_ch} < NUM_CH_L);

    always_comb begin
        err_set = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (err_acc && (int'(ev_err_ch) == i)) err_set[i] = 1'b1;
    end

    logic [NUM_CH-1:0] ena_q, eie_q, pend_q, err_q, done_q;
    logic [NUM_CH-1:0] ena_d, eie_d, pend_d, err_d, done_d;

    dma_csr_vec #(.NUM_CH(NUM_CH), .W1C(1'b0)) ena_vec_i (
        .clk(clk), .rst_n(rst_n), .ctl(ena_ctl), .wdata(reg_wdata),
        .hw_set('0), .bits_d(ena_d), .bits_q(ena_q));
    dma_csr_vec #(.NUM_CH(NUM_CH), .W1C(1'b0)) eie_vec_i (
        .clk(clk), .rst_n(rst_n), .ctl(eie_ctl), .wdata(reg_wdata),
        .hw_set('0), .bits_d(eie_d), .bits_q(eie_q));
    dma_csr_vec #(.NUM_CH(NUM_CH), .W1C(1'b1)) irq_vec_i (
        .clk(clk), .rst_n(rst_n), .ctl(irq_ctl), .wdata(reg_wdata),
        .hw_set(ev_int), .bits_d(pend_d), .bits_q(pend_q));
    dma_csr_vec #(.NUM_CH(NUM_CH), .W1C(1'b1)) err_vec_i (
        .clk(clk), .rst_n(rst_n), .ctl(err_ctl), .wdata(reg_wdata),
        .hw_set(err_set), .bits_d(err_d), .bits_q(err_q));
    dma_csr_vec #(.NUM_CH(NUM_CH), .W1C(1'b1)) done_vec_i (
        .clk(clk), .rst_n(rst_n), .ctl(done_ctl), .wdata(reg_wdata),
        .hw_set(ev_done), .bits_d(done_d), .bits_q(done_q));

    logic [WORD_W-1:0] estat_q;

    dma_csr_errstat errstat_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_vld   (err_acc),
        .cap_ch    (ev_err_ch),
        .cap_cause (ev_err_cause),
        .err_any_d (|err_d),
        .estat_q   (estat_q)
    );

    // start pulse register
    typedef struct packed {
        logic [NUM_CH-1:0] start;
    } start_st_t;

    start_st_t st_d, st_q;

    always_comb begin
        st_d.start = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (start_vld && (int'(start_ch) == i)) st_d.start[i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // widen every vector to two full words for the read mux
    logic [2*WORD_W-1:0] ena_x, eie_x, pend_x, err_x, done_x, hwrq_x;

    always_comb begin
        ena_x  = '0; ena_x[NUM_CH-1:0]  = ena_q;
        eie_x  = '0; eie_x[NUM_CH-1:0]  = eie_q;
        pend_x = '0; pend_x[NUM_CH-1:0] = pend_q;
        err_x  = '0; err_x[NUM_CH-1:0]  = err_q;
        done_x = '0; done_x[NUM_CH-1:0] = done_q;
        hwrq_x = '0; hwrq_x[NUM_CH-1:0] = hw_req;
    end

    always_comb begin
        case (reg_raddr)
            A_ENA_LO:  reg_rdata = ena_x[WORD_W-1:0];
            A_ENA_HI:  reg_rdata = ena_x[2*WORD_W-1:WORD_W];
            A_EIE_LO:  reg_rdata = eie_x[WORD_W-1:0];
            A_EIE_HI:  reg_rdata = eie_x[2*WORD_W-1:WORD_W];
            A_IRQ_LO:  reg_rdata = pend_x[WORD_W-1:0];
            A_IRQ_HI:  reg_rdata = pend_x[2*WORD_W-1:WORD_W];
            A_ERR_LO:  reg_rdata = err_x[WORD_W-1:0];
            A_ERR_HI:  reg_rdata = err_x[2*WORD_W-1:WORD_W];
            A_DONE_LO: reg_rdata = done_x[WORD_W-1:0];
            A_DONE_HI: reg_rdata = done_x[2*WORD_W-1:WORD_W];
            A_HWRQ_LO: reg_rdata = hwrq_x[WORD_W-1:0];
            A_HWRQ_HI: reg_rdata = hwrq_x[2*WORD_W-1:WORD_W];
            A_ESTAT:   reg_rdata = estat_q;
            default:   reg_rdata = '0;
        endcase
    end

    assign ch_enable = ena_q;
    assign ch_start  = st_q.start;
    assign irq       = (|pend_q) || (|(err_q & eie_q));
endmodule

// File: rtl/dma_csr_chk.sv
`timescale 1ns/1ps
module dma_csr_chk
    import dma_csr_pkg::*;
#(
    parameter int NUM_CH = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic                ev_err,
    input logic [CH_IDX_W-1:0] ev_err_ch,
    input logic [NUM_CH-1:0]   ch_start,
    input logic [NUM_CH-1:0]   ch_enable,
    input logic                irq,
    input logic [NUM_CH-1:0]   err_vec,
    input logic [WORD_W-1:0]   estat
);
    localparam logic [CH_IDX_W:0] NUM_CH_L = (CH_IDX_W+1)'(NUM_CH);

    AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_start)); // R6
    AST_START_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_start) |-> $past(reg_wr && (reg_addr == A_START))); // R6
    AST_ENA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(ch_enable)); // R2
    AST_ERR_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_err && ({1'b0, ev_err_ch} < NUM_CH_L)) |=> err_vec[$past(ev_err_ch)]); // R5
    AST_ESTAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(estat[31]) && (|err_vec)) |-> (estat == $past(estat))); // R8
    AST_ESTAT_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        !(|err_vec) |-> (estat == '0)); // R9
    AST_IRQ_FALL_BY_SW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(reg_wr)); // R10
endmodule

bind dma_chan_csr dma_csr_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .ev_err    (ev_err),
    .ev_err_ch (ev_err_ch),
    .ch_start  (ch_start),
    .ch_enable (ch_enable),
    .irq       (irq),
    .err_vec   (err_q),
    .estat     (estat_q)
);

// File: tb/dma_chan_csr_tb.sv
`timescale 1ns/1ps
module dma_chan_csr_tb_top;
    localparam int NCH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [4:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic [NCH-1:0] ev_done = '0, ev_int = '0, hw_req = '0;
    logic        ev_err = 1'b0;
    logic [5:0]  ev_err_ch = '0;
    logic [9:0]  ev_err_cause = '0;
    logic [NCH-1:0] ch_enable, ch_start;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dma_chan_csr #(.NUM_CH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .ev_done(ev_done), .ev_int(ev_int), .ev_err(ev_err),
        .ev_err_ch(ev_err_ch), .ev_err_cause(ev_err_cause), .hw_req(hw_req),
        .ch_enable(ch_enable), .ch_start(ch_start), .irq(irq));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_raddr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic chk_rd(input string req, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, {32'b0, v}, {32'b0, exp});
    endtask

    task automatic pulse_err(input logic [5:0] ch, input logic [9:0] cause);
        @(negedge clk);
        ev_err = 1'b1; ev_err_ch = ch; ev_err_cause = cause;
        @(negedge clk);
        ev_err = 1'b0;
    endtask

    task automatic t_reset();
        for (int a = 0; a < 13; a++) chk_rd("R1 reset read", 5'(a), 32'h0);
        check("R1 reset enable", ch_enable, 64'h0);
        check("R1 reset start", ch_start, 64'h0);
        check("R1 reset irq", {63'b0, irq}, 64'h0);
    endtask

    task automatic t_word_write();
        wr(5'd0, 32'hA5A5_0001);
        wr(5'd1, 32'h8000_0003);
        check("R2 enable vector", ch_enable, 64'h8000_0003_A5A5_0001);
        chk_rd("R2 enable hi readback", 5'd1, 32'h8000_0003);
        wr(5'd2, 32'h0000_1234);
        chk_rd("R2 eie lo readback", 5'd2, 32'h0000_1234);
        wr(5'd0, 32'h0); wr(5'd1, 32'h0); wr(5'd2, 32'h0);
        check("R2 enable cleared", ch_enable, 64'h0);
    endtask

    task automatic t_byte_ports();
        wr(5'd16, 32'd5);
        check("R3 set ch5", ch_enable, 64'h20);
        wr(5'd16, 32'd63);
        check("R3 set ch63", ch_enable, 64'h8000_0000_0000_0020);
        wr(5'd17, 32'd5);
        check("R3 clear ch5", ch_enable, 64'h8000_0000_0000_0000);
        wr(5'd16, 32'h45);
        check("R3 ignore bit6 set", ch_enable, 64'h8000_0000_0000_0000);
        wr(5'd17, 32'd63);
        check("R3 clear ch63", ch_enable, 64'h0);
        wr(5'd18, 32'd33);
        chk_rd("R3 set eie ch33", 5'd3, 32'h2);
        wr(5'd19, 32'd33);
        chk_rd("R3 clear eie ch33", 5'd3, 32'h0);
    endtask

    task automatic t_w1c();
        @(negedge clk);
        ev_int = '0; ev_int[0] = 1'b1; ev_int[1] = 1'b1; ev_int[40] = 1'b1;
        ev_done = '0; ev_done[7] = 1'b1; ev_done[50] = 1'b1;
        @(negedge clk);
        ev_int = '0; ev_done = '0;
        chk_rd("R5 int lo set", 5'd4, 32'h3);
        chk_rd("R5 int hi set", 5'd5, 32'h100);
        chk_rd("R5 done hi set", 5'd9, 32'h0004_0000);
        wr(5'd4, 32'h1);
        chk_rd("R4 w1c partial", 5'd4, 32'h2);
        wr(5'd5, 32'hFFFF_FFFF);
        chk_rd("R4 all ones clears", 5'd5, 32'h0);
        wr(5'd23, 32'd7);
        chk_rd("R4 clear done cmd", 5'd8, 32'h0);
        wr(5'd9, 32'hFFFF_FFFF);
        chk_rd("R4 done hi cleared", 5'd9, 32'h0);
        wr(5'd20, 32'd1);
        chk_rd("R4 clear int cmd", 5'd4, 32'h0);
    endtask

    task automatic t_collide();
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'd20; reg_wdata = 32'd3;
        ev_int = '0; ev_int[3] = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; ev_int = '0;
        chk_rd("R5 hw set beats clear", 5'd4, 32'h8);
        wr(5'd20, 32'd3);
        chk_rd("R5 later clear works", 5'd4, 32'h0);
    endtask

    task automatic t_start();
        wr(5'd22, 32'd12);
        check("R6 start pulse", ch_start, 64'h1000);
        @(negedge clk);
        check("R6 start one cycle", ch_start, 64'h0);
        wr(5'd22, 32'd64);
        check("R6 start out of range", ch_start, 64'h0);
    endtask

    task automatic t_estat();
        pulse_err(6'd5, 10'b10_1000_0001);
        chk_rd("R7 capture format", 5'd12, 32'h8000_8581);
        pulse_err(6'd9, 10'h042);
        chk_rd("R8 estat held", 5'd12, 32'h8000_8581);
        chk_rd("R8 second err bit", 5'd6, 32'h220);
        wr(5'd21, 32'd5);
        chk_rd("R8 held after partial clear", 5'd12, 32'h8000_8581);
        wr(5'd6, 32'hFFFF_FFFF);
        chk_rd("R9 rearm clears estat", 5'd12, 32'h0);
        pulse_err(6'd40, 10'h001);
        chk_rd("R9 recapture", 5'd12, 32'h8000_2801);
        chk_rd("R7 hi err bit", 5'd7, 32'h100);
        check("R10 no irq without eie", {63'b0, irq}, 64'h0);
        wr(5'd7, 32'hFFFF_FFFF);
        chk_rd("R9 cleared again", 5'd12, 32'h0);
    endtask

    task automatic t_irq();
        @(negedge clk); ev_int = '0; ev_int[2] = 1'b1;
        @(negedge clk); ev_int = '0;
        check("R10 irq from int", {63'b0, irq}, 64'h1);
        wr(5'd20, 32'd2);
        check("R10 irq cleared", {63'b0, irq}, 64'h0);
        pulse_err(6'd3, 10'h010);
        check("R10 masked error", {63'b0, irq}, 64'h0);
        wr(5'd18, 32'd3);
        check("R10 enabled error", {63'b0, irq}, 64'h1);
        wr(5'd19, 32'd3);
        check("R10 masked again", {63'b0, irq}, 64'h0);
        wr(5'd21, 32'd3);
    endtask

    task automatic t_hwreq();
        @(negedge clk);
        hw_req = 64'hDEAD_BEEF_0123_4567;
        chk_rd("R11 hwreq lo", 5'd10, 32'h0123_4567);
        chk_rd("R11 hwreq hi", 5'd11, 32'hDEAD_BEEF);
        hw_req = '0;
    endtask

    task automatic t_unmapped();
        chk_rd("R12 addr13", 5'd13, 32'h0);
        chk_rd("R12 addr15", 5'd15, 32'h0);
        chk_rd("R12 addr24", 5'd24, 32'h0);
        chk_rd("R12 addr31", 5'd31, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_word_write();
        t_byte_ports();
        t_w1c();
        t_collide();
        t_start();
        t_estat();
        t_irq();
        t_hwreq();
        t_unmapped();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule